// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter

This block holds the wall-clock time and date: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. A one-cycle pulse from an external divider marks each elapsed second. Every accepted pulse moves the time forward by exactly one second, and each carry ripples on to the larger fields in the same clock edge. The carries handle month lengths and leap years.

All fields use a single encoding, plain binary or packed BCD, chosen by one mode input. Hours count either 0 to 23 or 1 to 12 with a PM flag. Software loads any field through a small write port that takes a field code and a data byte. A freeze input holds the count steady while software loads a consistent set of fields. The mode inputs are expected to stay fixed between reloads of the fields.

Top module: `tod_calendar`

## Requirements
- R1: After a synchronous active-low reset, seconds, minutes, hours and year read 0x00, and day of week, day of month and month read 0x01.
- R2: A `sec_tick` pulse that is accepted advances the time by one second, with the result visible from the next rising edge. Seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours.
- R3: With `bin_mode`=1 every field is a plain binary number. With `bin_mode`=0 every field is packed BCD, with tens in bits 7:4 and units in bits 3:0, so 09 steps to 0x10. Every wrap point is the same decimal value in both encodings.
- R4: With `h24_mode`=1 the hours run from 0 to 23. Hour 23 wraps to 0 and starts a new day.
- R5: With `h24_mode`=0, bit 7 of the hours byte is the PM flag and bits 6:0 hold 1 to 12. The sequence is 12, 1, 2, ..., 11. Going from 11 to 12 flips the PM flag. Going from 12 to 1 leaves the flag as it is. Only 11 PM to 12 AM starts a new day.
- R6: Day of week counts 1 to 7, wraps to 1, and advances once on each new day.
- R7: Day of month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11; 31 for months 1, 3, 5, 7, 8, 10 and 12; for month 2, 29 when the year is a multiple of 4 and 28 otherwise. Each wrap advances the month.
- R8: Month 12 wraps to 1 and carries into the year. Year 99 wraps to 00.
- R9: While `freeze`=1 a second pulse is thrown away and is not held for later. The time does not move then or after `freeze` falls.
- R10: With `wr_en`=1, field code `wr_sel` (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year) loads `wr_data` at the rising edge. Writes work while `freeze`=1. Code 7 changes nothing.
- R11: Bit 7 of the seconds byte always reads 0, whatever is written to it.
- R12: A second pulse in the same cycle as a write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| freeze | input | 1 | Holds every field; pulses are discarded |
| bin_mode | input | 1 | 1 = binary fields, 0 = packed BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field code of the write |
| wr_data | input | 8 | Value to load, in the current encoding |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours, bit 7 = PM in 12-hour mode |
| wday_o | output | 8 | Day of week, 1 to 7 |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month, 1 to 12 |
| year_o | output | 8 | Two-digit year |

## Verification
Every result is due one rising edge after its stimulus. This covers a second pulse with its full carry ripple, a field write, a discarded pulse and reset. The whole carry chain resolves in the combinational path ahead of a single rank of registers. The bench drives inputs at the falling edge, lets exactly one rising edge pass, and compares all seven fields at the next falling edge. Its reference model is stepped in the same cycle. A cycle after a frozen pulse is also compared, so a pulse held over for later would show up there.

// File: rtl/tod_pkg.sv
// Shared types, field codes, limits and encoding helpers for the
// time-of-day counter. Assumes every field fits in one byte.
package tod_pkg;

    localparam int FIELD_W = 8;
    localparam int SEL_W   = 3;

    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_WDAY = 3'd3,
        SEL_MDAY = 3'd4,
        SEL_MON  = 3'd5,
        SEL_YEAR = 3'd6,
        SEL_NONE = 3'd7
    } fsel_e;

    localparam field_t SEC_LAST     = field_t'(59);
    localparam field_t MIN_LAST     = field_t'(59);
    localparam field_t HOUR24_LAST  = field_t'(23);
    localparam field_t HOUR12_PRE   = field_t'(11);
    localparam field_t HOUR12_TOP   = field_t'(12);
    localparam field_t WDAY_LAST    = field_t'(7);
    localparam field_t MON_LAST     = field_t'(12);
    localparam field_t YEAR_LAST    = field_t'(99);
    localparam field_t LEAP_STEP    = field_t'(4);
    localparam field_t ZERO_BASE    = field_t'(0);
    localparam field_t ONE_BASE     = field_t'(1);

    // Packed BCD byte to binary value.
    function automatic field_t bcd_to_bin(field_t b);
        return field_t'(b[7:4]) * field_t'(10) + field_t'(b[3:0]);
    endfunction

    // Binary value below 100 to packed BCD byte.
    function automatic field_t bin_to_bcd(field_t v);
        field_t tens;
        field_t ones;
        tens = v / field_t'(10);
        ones = v % field_t'(10);
        return {tens[3:0], ones[3:0]};
    endfunction

    // Stored byte to binary value under the selected encoding.
    function automatic field_t decode(field_t raw, logic bin);
        return bin ? raw : bcd_to_bin(raw);
    endfunction

    // Binary value to stored byte under the selected encoding.
    function automatic field_t encode(field_t v, logic bin);
        return bin ? v : bin_to_bcd(v);
    endfunction

endpackage

// File: rtl/tod_wrap_field.sv
// One wrapping field of the counter. When stepped, it moves to the next
// value, or back to `first` once the value is at or past `last`, and then
// raises carry. Comparison happens on the decoded value, so binary and BCD
// wrap at the same point. Assumes `first` and `last` are binary values.
module tod_wrap_field
    import tod_pkg::*;
(
    input  field_t cur,
    input  field_t first,
    input  field_t last,
    input  logic   bin_mode,
    input  logic   step,
    output field_t nxt,
    output logic   carry
);

    field_t val;
    logic   at_end;

    // Next-value and carry selection for this field.
    always_comb begin
        val    = decode(cur, bin_mode);
        at_end = (val >= last);
        carry  = step && at_end;
        if (!step) begin
            nxt = cur;
        end else if (at_end) begin
            nxt = encode(first, bin_mode);
        end else begin
            nxt = encode(val + ONE_BASE, bin_mode);
        end
    end

endmodule

// File: rtl/tod_hour_step.sv
// Hours field stepping for both clock formats. 24-hour: 0..23, wrapping to
// 0 with a day carry. 12-hour: bit 7 is the PM flag. The sequence is 12,1..11,
// and 11->12 flips the flag. The day carry comes only when the flag goes from
// PM to AM. Assumes hour bits 6:0 hold a value in the current encoding.
module tod_hour_step
    import tod_pkg::*;
(
    input  field_t cur,
    input  logic   bin_mode,
    input  logic   h24_mode,
    input  logic   step,
    output field_t nxt,
    output logic   carry
);

    field_t     hv;
    field_t     inc_enc;
    logic [6:0] inc7;
    logic [6:0] one7;
    logic [6:0] twelve7;
    logic       pm;

    // Hour successor and day carry under the selected format.
    always_comb begin
        pm      = cur[7];
        hv      = decode({1'b0, cur[6:0]}, bin_mode);
        inc_enc = encode(hv + ONE_BASE, bin_mode);
        inc7    = 7'(inc_enc);
        one7    = 7'(encode(ONE_BASE, bin_mode));
        twelve7 = 7'(encode(HOUR12_TOP, bin_mode));
        nxt     = cur;
        carry   = 1'b0;
        if (step) begin
            if (h24_mode) begin
                if (hv >= HOUR24_LAST) begin
                    nxt   = encode(ZERO_BASE, bin_mode);
                    carry = 1'b1;
                end else begin
                    nxt = inc_enc;
                end
            end else begin
                if (hv == HOUR12_PRE) begin
                    nxt   = {~pm, twelve7};
                    carry = pm;
                end else if (hv >= HOUR12_TOP) begin
                    nxt = {pm, one7};
                end else begin
                    nxt = {pm, inc7};
                end
            end
        end
    end

endmodule

// File: rtl/tod_month_len.sv
// Last day of the month from the stored month and year bytes. A year is
// a leap year when its two-digit value is a multiple of four. Assumes the
// month holds 1..12; any other value is treated as a 31-day month.
module tod_month_len
    import tod_pkg::*;
(
    input  field_t mon_raw,
    input  field_t year_raw,
    input  logic   bin_mode,
    output field_t last_day
);

    field_t mon;
    field_t yr;
    logic   leap;

    // Month length lookup with leap-year February.
    always_comb begin
        mon  = decode(mon_raw, bin_mode);
        yr   = decode(year_raw, bin_mode);
        leap = ((yr % LEAP_STEP) == ZERO_BASE);
        case (mon)
            field_t'(2):  last_day = leap ? field_t'(29) : field_t'(28);
            field_t'(4),
            field_t'(6),
            field_t'(9),
            field_t'(11): last_day = field_t'(30);
            default:      last_day = field_t'(31);
        endcase
    end

endmodule

// File: rtl/tod_calendar.sv
// Time-of-day and calendar counter. Each accepted second pulse advances all
// fields, and the carries ripple through the whole chain combinationally
// ahead of one register rank. Writes take priority over pulses. Freeze
// discards pulses. Assumes the encoding and hour format stay fixed between
// full reloads of the fields.
module tod_calendar
    import tod_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic               freeze,
    input  logic               bin_mode,
    input  logic               h24_mode,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [FIELD_W-1:0] wr_data,
    output logic [FIELD_W-1:0] sec_o,
    output logic [FIELD_W-1:0] min_o,
    output logic [FIELD_W-1:0] hour_o,
    output logic [FIELD_W-1:0] wday_o,
    output logic [FIELD_W-1:0] mday_o,
    output logic [FIELD_W-1:0] mon_o,
    output logic [FIELD_W-1:0] year_o
);

    field_t sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q;
    field_t sec_n, min_n, hour_n, wday_n, mday_n, mon_n, year_n;
    field_t mday_last;
    logic   c_sec, c_min, c_hour, c_wday, c_mday, c_mon, c_year;
    logic   advance;
    logic   unused_carries;

    assign advance        = sec_tick && !freeze && !wr_en;
    assign unused_carries = c_wday ^ c_year;

    tod_wrap_field u_sec (
        .cur      ({1'b0, sec_q[6:0]}),
        .first    (ZERO_BASE),
        .last     (SEC_LAST),
        .bin_mode (bin_mode),
        .step     (advance),
        .nxt      (sec_n),
        .carry    (c_sec)
    );

    tod_wrap_field u_min (
        .cur      (min_q),
        .first    (ZERO_BASE),
        .last     (MIN_LAST),
        .bin_mode (bin_mode),
        .step     (c_sec),
        .nxt      (min_n),
        .carry    (c_min)
    );

    tod_hour_step u_hour (
        .cur      (hour_q),
        .bin_mode (bin_mode),
        .h24_mode (h24_mode),
        .step     (c_min),
        .nxt      (hour_n),
        .carry    (c_hour)
    );

    tod_wrap_field u_wday (
        .cur      (wday_q),
        .first    (ONE_BASE),
        .last     (WDAY_LAST),
        .bin_mode (bin_mode),
        .step     (c_hour),
        .nxt      (wday_n),
        .carry    (c_wday)
    );

    tod_month_len u_mlen (
        .mon_raw  (mon_q),
        .year_raw (year_q),
        .bin_mode (bin_mode),
        .last_day (mday_last)
    );

    tod_wrap_field u_mday (
        .cur      (mday_q),
        .first    (ONE_BASE),
        .last     (mday_last),
        .bin_mode (bin_mode),
        .step     (c_hour),
        .nxt      (mday_n),
        .carry    (c_mday)
    );

    tod_wrap_field u_mon (
        .cur      (mon_q),
        .first    (ONE_BASE),
        .last     (MON_LAST),
        .bin_mode (bin_mode),
        .step     (c_mday),
        .nxt      (mon_n),
        .carry    (c_mon)
    );

    tod_wrap_field u_year (
        .cur      (year_q),
        .first    (ZERO_BASE),
        .last     (YEAR_LAST),
        .bin_mode (bin_mode),
        .step     (c_mon),
        .nxt      (year_n),
        .carry    (c_year)
    );

    // Field registers: reset, then software write, then a second step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= ZERO_BASE;
            min_q  <= ZERO_BASE;
            hour_q <= ZERO_BASE;
            wday_q <= ONE_BASE;
            mday_q <= ONE_BASE;
            mon_q  <= ONE_BASE;
            year_q <= ZERO_BASE;
        end else if (wr_en) begin
            case (fsel_e'(wr_sel))
                SEL_SEC:  sec_q  <= {1'b0, wr_data[6:0]};
                SEL_MIN:  min_q  <= wr_data;
                SEL_HOUR: hour_q <= wr_data;
                SEL_WDAY: wday_q <= wr_data;
                SEL_MDAY: mday_q <= wr_data;
                SEL_MON:  mon_q  <= wr_data;
                SEL_YEAR: year_q <= wr_data;
                default:  ;
            endcase
        end else if (advance) begin
            sec_q  <= sec_n;
            min_q  <= min_n;
            hour_q <= hour_n;
            wday_q <= wday_n;
            mday_q <= mday_n;
            mon_q  <= mon_n;
            year_q <= year_n;
        end
    end

    assign sec_o  = sec_q;
    assign min_o  = min_q;
    assign hour_o = hour_q;
    assign wday_o = wday_q;
    assign mday_o = mday_q;
    assign mon_o  = mon_q;
    assign year_o = year_q;

endmodule

// File: rtl/tod_calendar_chk.sv
// Port-level properties of the time-of-day counter, bound to every
// instance of tod_calendar. Assumes synchronous active-low reset.
module tod_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       freeze,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] wday_o,
    input logic [7:0] mday_o,
    input logic [7:0] mon_o,
    input logic [7:0] year_o
);

    // R11
    sec_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o[7] == 1'b0);

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
            && $stable(wday_o) && $stable(mday_o) && $stable(mon_o) && $stable(year_o)));

    // R2
    tick_moves_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !freeze && !wr_en) |=> !$stable(sec_o));

    // R10
    write_load_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd1) |=> (min_o == $past(wr_data)));

    // R12
    write_blocks_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != 3'd0) |=> $stable(sec_o));

    // R8
    year_follows_month_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(year_o) || !$stable(mon_o)));

endmodule

bind tod_calendar tod_calendar_chk u_chk (.*);

// File: tb/tod_calendar_test.sv
`timescale 1ns/1ps
module tod_calendar_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       freeze = 1'b0;
    logic       bin_mode = 1'b1;
    logic       h24_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_sec, m_min, m_hr, m_wd, m_md, m_mo, m_yr;
    bit m_pm;

    always #2 clk = ~clk;

    tod_calendar uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .freeze(freeze),
        .bin_mode(bin_mode), .h24_mode(h24_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o),
        .year_o(year_o)
    );

    // Encode a value 0..99 the way the current mode stores it (R3).
    function automatic logic [7:0] enc8(int v);
        if (bin_mode) return 8'(v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic logic [7:0] hour_byte(int h, bit pm);
        logic [7:0] e;
        e = enc8(h);
        if (h24_mode) return e;
        return {pm, e[6:0]};
    endfunction

    // Month length by the R7 rule.
    function automatic int month_days(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_pm = 1'b0;
        m_wd = 1; m_md = 1; m_mo = 1; m_yr = 0;
    endtask

    task automatic model_day();
        m_wd = (m_wd == 7) ? 1 : m_wd + 1;
        m_md = m_md + 1;
        if (m_md > month_days(m_mo, m_yr)) begin
            m_md = 1;
            m_mo = m_mo + 1;
            if (m_mo == 13) begin
                m_mo = 1;
                m_yr = (m_yr + 1) % 100;
            end
        end
    endtask

    task automatic model_tick();
        m_sec = m_sec + 1;
        if (m_sec == 60) begin
            m_sec = 0;
            m_min = m_min + 1;
            if (m_min == 60) begin
                m_min = 0;
                if (h24_mode) begin
                    m_hr = m_hr + 1;
                    if (m_hr == 24) begin
                        m_hr = 0;
                        model_day();
                    end
                end else if (m_hr == 11) begin
                    m_hr = 12;
                    m_pm = ~m_pm;
                    if (!m_pm) model_day();
                end else if (m_hr >= 12) begin
                    m_hr = 1;
                end else begin
                    m_hr = m_hr + 1;
                end
            end
        end
    endtask

    task automatic cmp(string tag, string name, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, name, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "sec",  sec_o,  enc8(m_sec));
        cmp(tag, "min",  min_o,  enc8(m_min));
        cmp(tag, "hour", hour_o, hour_byte(m_hr, m_pm));
        cmp(tag, "wday", wday_o, enc8(m_wd));
        cmp(tag, "mday", mday_o, enc8(m_md));
        cmp(tag, "mon",  mon_o,  enc8(m_mo));
        cmp(tag, "year", year_o, enc8(m_yr));
    endtask

    // Present inputs (called at a falling edge) and pass one rising edge.
    task automatic drive(bit tk, bit fz, bit we, logic [2:0] sel, logic [7:0] d);
        sec_tick = tk; freeze = fz; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
    endtask

    task automatic settle_check(string tag);
        @(negedge clk);
        sec_tick = 1'b0; freeze = 1'b0; wr_en = 1'b0;
        check_all(tag);
    endtask

    task automatic put_field(int sel, int v, bit pm, bit tk, bit fz, string tag);
        logic [7:0] d;
        d = (sel == 2) ? hour_byte(v, pm) : enc8(v);
        drive(tk, fz, 1'b1, 3'(sel), d);
        case (sel)
            0: m_sec = v;
            1: m_min = v;
            2: begin m_hr = v; m_pm = h24_mode ? 1'b0 : pm; end
            3: m_wd = v;
            4: m_md = v;
            5: m_mo = v;
            6: m_yr = v;
            default: ;
        endcase
        settle_check(tag);
    endtask

    task automatic load_all(int h, bit pm, int mi, int s, int wd, int md, int mo, int yr);
        put_field(0, s,  1'b0, 1'b0, 1'b1, "R10");
        put_field(1, mi, 1'b0, 1'b0, 1'b1, "R10");
        put_field(2, h,  pm,   1'b0, 1'b1, "R10");
        put_field(3, wd, 1'b0, 1'b0, 1'b1, "R10");
        put_field(4, md, 1'b0, 1'b0, 1'b1, "R10");
        put_field(5, mo, 1'b0, 1'b0, 1'b1, "R10");
        put_field(6, yr, 1'b0, 1'b0, 1'b1, "R10");
    endtask

    task automatic tick_once(string tag);
        drive(1'b1, 1'b0, 1'b0, 3'd0, 8'd0);
        model_tick();
        settle_check(tag);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 3'd0, 8'd0);
        settle_check("R1");
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int last_h;
        void'($urandom(32'd20240611));
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            bin_mode = p[0];
            h24_mode = !p[1];
            apply_reset();
            last_h = h24_mode ? 23 : 11;

            // R4 R5 R6 R8: last second of the century wraps every field.
            load_all(last_h, 1'b1, 59, 59, 7, 31, 12, 99);
            tick_once("R4 R5 R6 R8");

            // R7: month lengths and leap February.
            load_all(last_h, 1'b1, 59, 59, 3, 28, 2, 24);
            tick_once("R7");
            load_all(last_h, 1'b1, 59, 59, 4, 29, 2, 24);
            tick_once("R7");
            load_all(last_h, 1'b1, 59, 59, 5, 28, 2, 23);
            tick_once("R7");
            load_all(last_h, 1'b1, 59, 59, 6, 30, 4, 23);
            tick_once("R7");
            load_all(last_h, 1'b1, 59, 59, 2, 31, 1, 23);
            tick_once("R7");
            load_all(last_h, 1'b1, 59, 59, 2, 30, 12, 50);
            tick_once("R7");

            // R5: noon flips the flag without a new day; 12 -> 1 keeps it.
            if (!h24_mode) begin
                load_all(11, 1'b0, 59, 59, 3, 10, 6, 30);
                tick_once("R5");
                load_all(12, 1'b1, 59, 59, 3, 10, 6, 30);
                tick_once("R5");
            end

            // R3: digit carry inside the minutes and seconds.
            load_all(5, 1'b0, 9, 9, 2, 9, 9, 9);
            tick_once("R3");
            load_all(5, 1'b0, 9, 59, 2, 9, 9, 9);
            tick_once("R3");

            // R9: a frozen pulse is dropped and never replayed.
            drive(1'b1, 1'b1, 1'b0, 3'd0, 8'd0);
            settle_check("R9");
            drive(1'b0, 1'b0, 1'b0, 3'd0, 8'd0);
            settle_check("R9");

            // R10: field code 7 changes nothing.
            drive(1'b0, 1'b0, 1'b1, 3'd7, 8'h55);
            settle_check("R10");

            // R11: seconds bit 7 is not stored.
            drive(1'b0, 1'b1, 1'b1, 3'd0, enc8(45) | 8'h80);
            m_sec = 45;
            settle_check("R11");

            // R12: a pulse beside a write is discarded.
            put_field(1, 17, 1'b0, 1'b1, 1'b0, "R12");

            // Random traffic against the model.
            for (int i = 0; i < 2500; i++) begin
                int r;
                int sel;
                int v;
                r = $urandom % 100;
                if (r < 55) begin
                    tick_once("R2");
                end else if (r < 68) begin
                    drive(1'b1, 1'b1, 1'b0, 3'd0, 8'd0);
                    settle_check("R9");
                end else if (r < 85) begin
                    sel = $urandom % 8;
                    case (sel)
                        0, 1: v = $urandom % 60;
                        2: v = h24_mode ? ($urandom % 24) : (1 + $urandom % 12);
                        3: v = 1 + $urandom % 7;
                        4: v = 1 + $urandom % 28;
                        5: v = 1 + $urandom % 12;
                        default: v = $urandom % 100;
                    endcase
                    if (sel == 7) begin
                        drive(1'b0, 1'b0, 1'b1, 3'd7, 8'($urandom));
                        settle_check("R10");
                    end else begin
                        put_field(sel, v, 1'($urandom), 1'($urandom), 1'($urandom), "R10 R12");
                    end
                end else begin
                    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'd0);
                    settle_check("R2");
                end
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule